// File: doc/BRIEF.md
# Shift-and-Add Overflow Detector

This block is the front end of an integer adder that scales its first operand by a left shift of 0 to 3 places before adding the second operand and an optional carry-in. It works on full 64-bit doublewords or on 32-bit words held in the low half of the datapath. Next to the sum, it reports a signed-overflow flag and an unsigned-overflow flag. A 4-bit condition code is evaluated against the sum and both flags. A trap request is raised when signed overflow occurs and trapping is enabled.

The two flags do not describe the addition alone. They also cover the pre-shift: bits that move into or through the sign position of the first operand, and bits that leave its upper end, count as overflow. Every output is registered once. Results appear one clock after the operands are presented.

Top module: `shadd_ovf`

## Requirements
- R1: One clock after the inputs are applied, `sum_o` equals `(in_a << shamt) + in_b + carry_in`, taken modulo 2^64.
- R2: The base signed overflow is set when the shifted first operand and `in_b` have the same sign bit and the sum's sign bit differs from it. The sign bit is bit 63 when `wide_mode`=1 and bit 31 when `wide_mode`=0.
- R3: With `shamt`=1, `sv_o` is also set when bit S-1 of the unshifted `in_a` differs from its sign bit S.
- R4: With `shamt`=2 or 3, `sv_o` is also set when any of bits S-1 down to S-`shamt` of the unshifted `in_a` differs from bit S.
- R5: With `shamt`=0, `uv_o` equals the adder carry. In wide mode that is the carry out of bit 63. In word mode it is the carry into bit 32.
- R6: With `shamt`>0, `uv_o` is that carry ORed with any set bit among bits S-1 down to S-`shamt` of the unshifted `in_a`.
- R7: The condition select is `cond_code[3:1]`, where Z is a zero sum and N is the sum's sign bit S. Its values are: 0 never, 1 Z, 2 N xor sv, 3 (N xor sv) or Z, 4 not uv, 5 (not uv) or Z, 6 sv, 7 sum bit 0 set. `cond_code[0]`=1 inverts the result.
- R8: In word mode the zero and sign tests use only bits 31:0 of the sum.
- R9: `trap_o` equals `trap_en` AND the signed-overflow flag for the same operands.
- R10: While `rst_n` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_a | input | 64 | Operand that is pre-shifted |
| in_b | input | 64 | Second addend |
| carry_in | input | 1 | Carry into bit 0 |
| shamt | input | 2 | Left pre-shift amount of `in_a` |
| wide_mode | input | 1 | 1 selects 64-bit mode, 0 selects 32-bit mode |
| cond_code | input | 4 | Condition select in bits 3:1, invert in bit 0 |
| trap_en | input | 1 | Enables the overflow trap request |
| sum_o | output | 64 | Registered sum |
| sv_o | output | 1 | Signed overflow, including pre-shift overflow |
| uv_o | output | 1 | Unsigned overflow, including bits lost by the pre-shift |
| cond_o | output | 1 | Evaluated condition |
| trap_o | output | 1 | Trap request on signed overflow |

## Verification
The bound checker verifies the following on every clock:
- the registered sum against a plain shift-and-add;
- the never and always conditions;
- the link between the signed-overflow select and `sv_o`;
- that the trap request follows `trap_en` and `sv_o`;
- that operands of opposite sign never report overflow when no shift is applied.

The remaining behaviours are shown only by the bench's scenarios. These are:
- the pre-shift contributions to both flags at each shift amount;
- word-mode carries taken at bit 32;
- zero and sign tests restricted to the low half;
- the remaining condition codes.

// File: rtl/shadd_pkg.sv
package shadd_pkg;

   // Condition selector carried in the upper three bits of the condition code.
   typedef enum logic [2:0] {
      CC_NEVER = 3'd0,
      CC_ZERO  = 3'd1,
      CC_LT    = 3'd2,
      CC_LE    = 3'd3,
      CC_NUV   = 3'd4,
      CC_ZNUV  = 3'd5,
      CC_SV    = 3'd6,
      CC_ODD   = 3'd7
   } cc_sel_e;

endpackage

// File: rtl/shadd_preshift.sv
// Pre-shift of operand A and the overflow contributions of the shift itself.
module shadd_preshift #(
   parameter int DATA_W = 64,
   parameter int SH_W   = 2
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [SH_W-1:0]   sh_i,
   input  logic              wide_i,
   output logic [DATA_W-1:0] shifted_o,
   output logic              sv_shift_o,
   output logic              uv_shift_o
);
   localparam int HALF_W = DATA_W / 2;
   localparam int MAX_SH = (1 << SH_W) - 1;
   localparam int SW     = DATA_W - 1;
   localparam int SN     = HALF_W - 1;

   logic [MAX_SH:1] in_reach;
   logic [MAX_SH:1] diff_w, diff_n;
   logic [MAX_SH:1] bit_w, bit_n;

   assign shifted_o = a_i << sh_i;

   // One slot per bit position a shift can push into or past the sign.
   for (genvar k = 1; k <= MAX_SH; k++) begin : g_slot
      assign in_reach[k] = (int'(sh_i) >= k);
      assign diff_w[k]   = a_i[SW-k] ^ a_i[SW];
      assign diff_n[k]   = a_i[SN-k] ^ a_i[SN];
      assign bit_w[k]    = a_i[SW-k];
      assign bit_n[k]    = a_i[SN-k];
   end

   always_comb begin
      if (wide_i) begin
         sv_shift_o = |(diff_w & in_reach);
         uv_shift_o = |(bit_w & in_reach);
      end else begin
         sv_shift_o = |(diff_n & in_reach);
         uv_shift_o = |(bit_n & in_reach);
      end
   end
endmodule

// File: rtl/shadd_adder.sv
// Split adder: the low half yields the word-mode carry, the high half the doubleword carry.
module shadd_adder #(
   parameter int DATA_W = 64
) (
   input  logic [DATA_W-1:0] sa_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              cin_i,
   input  logic              wide_i,
   output logic [DATA_W-1:0] sum_o,
   output logic              carry_o,
   output logic              sv_base_o
);
   localparam int HALF_W = DATA_W / 2;

   logic [HALF_W:0] lo_sum, hi_sum;
   logic            sgn_a, sgn_b, sgn_s;

   assign lo_sum = {1'b0, sa_i[HALF_W-1:0]} + {1'b0, b_i[HALF_W-1:0]}
                 + {{HALF_W{1'b0}}, cin_i};
   assign hi_sum = {1'b0, sa_i[DATA_W-1:HALF_W]} + {1'b0, b_i[DATA_W-1:HALF_W]}
                 + {{HALF_W{1'b0}}, lo_sum[HALF_W]};

   assign sum_o   = {hi_sum[HALF_W-1:0], lo_sum[HALF_W-1:0]};
   assign carry_o = wide_i ? hi_sum[HALF_W] : lo_sum[HALF_W];

   always_comb begin
      if (wide_i) begin
         sgn_a = sa_i[DATA_W-1];
         sgn_b = b_i[DATA_W-1];
         sgn_s = sum_o[DATA_W-1];
      end else begin
         sgn_a = sa_i[HALF_W-1];
         sgn_b = b_i[HALF_W-1];
         sgn_s = sum_o[HALF_W-1];
      end
   end

   assign sv_base_o = ~(sgn_a ^ sgn_b) & (sgn_s ^ sgn_a);
endmodule

// File: rtl/shadd_cond.sv
// Evaluates the arithmetic condition selector against the sum and the flags.
module shadd_cond
   import shadd_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  logic [DATA_W-1:0] sum_i,
   input  logic              sv_i,
   input  logic              uv_i,
   input  logic              wide_i,
   input  logic [3:0]        code_i,
   output logic              flag_o
);
   localparam int HALF_W = DATA_W / 2;

   logic    is_zero, is_neg, raw;
   cc_sel_e sel;

   assign is_zero = wide_i ? (sum_i == '0) : (sum_i[HALF_W-1:0] == '0);
   assign is_neg  = wide_i ? sum_i[DATA_W-1] : sum_i[HALF_W-1];
   assign sel     = cc_sel_e'(code_i[3:1]);

   always_comb begin
      unique case (sel)
         CC_NEVER: raw = 1'b0;
         CC_ZERO:  raw = is_zero;
         CC_LT:    raw = is_neg ^ sv_i;
         CC_LE:    raw = (is_neg ^ sv_i) | is_zero;
         CC_NUV:   raw = ~uv_i;
         CC_ZNUV:  raw = ~uv_i | is_zero;
         CC_SV:    raw = sv_i;
         CC_ODD:   raw = sum_i[0];
         default:  raw = 1'b0;
      endcase
   end

   assign flag_o = raw ^ code_i[0];
endmodule

// File: rtl/shadd_ovf.sv
// Shift-and-add front end with registered sum, overflow flags and condition.
module shadd_ovf #(
   parameter int DATA_W = 64,
   parameter int SH_W   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] in_a,
   input  logic [DATA_W-1:0] in_b,
   input  logic              carry_in,
   input  logic [SH_W-1:0]   shamt,
   input  logic              wide_mode,
   input  logic [3:0]        cond_code,
   input  logic              trap_en,
   output logic [DATA_W-1:0] sum_o,
   output logic              sv_o,
   output logic              uv_o,
   output logic              cond_o,
   output logic              trap_o
);
   localparam int HALF_W = DATA_W / 2;
   localparam int MAX_SH = (1 << SH_W) - 1;

   if ((DATA_W % 2) != 0 || MAX_SH >= HALF_W || SH_W < 1) begin : g_bad_params
      $error("shadd_ovf: DATA_W must be even and the maximum shift below half the width");
   end

   logic [DATA_W-1:0] shifted, sum_c;
   logic              sv_shift, uv_shift, carry, sv_base;
   logic              sv_c, uv_c, flag_c;

   shadd_preshift #(.DATA_W(DATA_W), .SH_W(SH_W)) u_pre (
      .a_i       (in_a),
      .sh_i      (shamt),
      .wide_i    (wide_mode),
      .shifted_o (shifted),
      .sv_shift_o(sv_shift),
      .uv_shift_o(uv_shift)
   );

   shadd_adder #(.DATA_W(DATA_W)) u_add (
      .sa_i     (shifted),
      .b_i      (in_b),
      .cin_i    (carry_in),
      .wide_i   (wide_mode),
      .sum_o    (sum_c),
      .carry_o  (carry),
      .sv_base_o(sv_base)
   );

   assign sv_c = sv_base | sv_shift;
   assign uv_c = carry | uv_shift;

   shadd_cond #(.DATA_W(DATA_W)) u_cond (
      .sum_i (sum_c),
      .sv_i  (sv_c),
      .uv_i  (uv_c),
      .wide_i(wide_mode),
      .code_i(cond_code),
      .flag_o(flag_c)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sum_o  <= '0;
         sv_o   <= 1'b0;
         uv_o   <= 1'b0;
         cond_o <= 1'b0;
         trap_o <= 1'b0;
      end else begin
         sum_o  <= sum_c;
         sv_o   <= sv_c;
         uv_o   <= uv_c;
         cond_o <= flag_c;
         trap_o <= trap_en & sv_c;
      end
   end
endmodule

// File: rtl/shadd_ovf_chk.sv
module shadd_ovf_chk #(
   parameter int DATA_W = 64,
   parameter int SH_W   = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [DATA_W-1:0] in_a,
   input logic [DATA_W-1:0] in_b,
   input logic              carry_in,
   input logic [SH_W-1:0]   shamt,
   input logic              wide_mode,
   input logic [3:0]        cond_code,
   input logic              trap_en,
   input logic [DATA_W-1:0] sum_o,
   input logic              sv_o,
   input logic              uv_o,
   input logic              cond_o,
   input logic              trap_o
);
   logic [DATA_W:0] plain_ext;
   assign plain_ext = {1'b0, in_a} + {1'b0, in_b} + {{DATA_W{1'b0}}, carry_in};

   // R1
   a_r1_sum: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> sum_o == (($past(in_a) << $past(shamt)) + $past(in_b)
                                 + {{(DATA_W-1){1'b0}}, $past(carry_in)}));

   // R2
   a_r2_mixed_sign_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(shamt) == '0 && $past(wide_mode)
       && ($past(in_a[DATA_W-1]) != $past(in_b[DATA_W-1]))) |-> !sv_o);

   // R5
   a_r5_wide_carry: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(shamt) == '0 && $past(wide_mode))
      |-> uv_o == $past(plain_ext[DATA_W]));

   // R7
   a_r7_never: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(cond_code) == 4'd0) |-> !cond_o);

   // R7
   a_r7_always: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(cond_code) == 4'd1) |-> cond_o);

   // R7
   a_r7_sv_select: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(cond_code[3:1]) == 3'd6)
      |-> cond_o == (sv_o ^ $past(cond_code[0])));

   // R9
   a_r9_trap: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> trap_o == ($past(trap_en) && sv_o));
endmodule

bind shadd_ovf shadd_ovf_chk #(.DATA_W(DATA_W), .SH_W(SH_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_a     (in_a),
   .in_b     (in_b),
   .carry_in (carry_in),
   .shamt    (shamt),
   .wide_mode(wide_mode),
   .cond_code(cond_code),
   .trap_en  (trap_en),
   .sum_o    (sum_o),
   .sv_o     (sv_o),
   .uv_o     (uv_o),
   .cond_o   (cond_o),
   .trap_o   (trap_o)
);

// File: tb/shadd_ovf_bench.sv
module shadd_ovf_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] in_a = '0, in_b = '0;
   logic        carry_in = 1'b0, wide_mode = 1'b0, trap_en = 1'b0;
   logic [1:0]  shamt = '0;
   logic [3:0]  cond_code = '0;
   logic [63:0] sum_o;
   logic        sv_o, uv_o, cond_o, trap_o;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   shadd_ovf u_shadd_ovf (
      .clk(clk), .rst_n(rst_n), .in_a(in_a), .in_b(in_b), .carry_in(carry_in),
      .shamt(shamt), .wide_mode(wide_mode), .cond_code(cond_code), .trap_en(trap_en),
      .sum_o(sum_o), .sv_o(sv_o), .uv_o(uv_o), .cond_o(cond_o), .trap_o(trap_o)
   );

   task automatic chk(input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // Behavioural reference written from the requirements.
   task automatic ref_model(input logic [63:0] a, input logic [63:0] b, input logic ci,
                            input logic [1:0] sh, input logic wide, input logic [3:0] cc,
                            input logic te,
                            output logic [63:0] e_sum, output logic e_sv, output logic e_uv,
                            output logic e_cond, output logic e_trap);
      int          s;
      logic [63:0] sa;
      logic [64:0] full;
      logic [32:0] low;
      logic        carry, base, shift_sv, lost, z, n, f;
      s     = wide ? 63 : 31;
      sa    = a << sh;
      full  = {1'b0, sa} + {1'b0, b} + {64'd0, ci};
      low   = {1'b0, sa[31:0]} + {1'b0, b[31:0]} + {32'd0, ci};
      e_sum = full[63:0];
      carry = wide ? full[64] : low[32];
      base  = (sa[s] == b[s]) && (e_sum[s] != sa[s]);
      shift_sv = 1'b0;
      lost     = 1'b0;
      for (int k = 1; k <= int'(sh); k++) begin
         if (a[s-k] != a[s]) shift_sv = 1'b1;
         if (a[s-k]) lost = 1'b1;
      end
      e_sv = base | shift_sv;
      e_uv = carry | lost;
      z = wide ? (e_sum == 64'd0) : (e_sum[31:0] == 32'd0);
      n = e_sum[s];
      case (cc[3:1])
         3'd0: f = 1'b0;
         3'd1: f = z;
         3'd2: f = n ^ e_sv;
         3'd3: f = (n ^ e_sv) | z;
         3'd4: f = !e_uv;
         3'd5: f = !e_uv | z;
         3'd6: f = e_sv;
         default: f = e_sum[0];
      endcase
      e_cond = f ^ cc[0];
      e_trap = te & e_sv;
   endtask

   task automatic apply(input string tag, input logic [63:0] a, input logic [63:0] b,
                        input logic ci, input logic [1:0] sh, input logic wide,
                        input logic [3:0] cc, input logic te);
      logic [63:0] e_sum;
      logic        e_sv, e_uv, e_cond, e_trap;
      @(negedge clk);
      in_a = a; in_b = b; carry_in = ci; shamt = sh;
      wide_mode = wide; cond_code = cc; trap_en = te;
      @(posedge clk);
      @(negedge clk);
      ref_model(a, b, ci, sh, wide, cc, te, e_sum, e_sv, e_uv, e_cond, e_trap);
      chk("R1", "sum", sum_o, e_sum);
      chk(tag, "sv", {63'd0, sv_o}, {63'd0, e_sv});
      chk(tag, "uv", {63'd0, uv_o}, {63'd0, e_uv});
      chk(tag, "cond", {63'd0, cond_o}, {63'd0, e_cond});
      chk("R9", "trap", {63'd0, trap_o}, {63'd0, e_trap});
   endtask

   task automatic summary;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_fail++;
         n_run++;
         $display("FAIL watchdog expired actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      in_a = 64'hFFFF_0000_1234_5678;
      in_b = 64'h1;
      trap_en = 1'b1;
      repeat (3) @(negedge clk);
      // R10: outputs stay zero in reset
      chk("R10", "sum", sum_o, 64'd0);
      chk("R10", "flags", {59'd0, sv_o, uv_o, cond_o, trap_o, 1'b0}, 64'd0);
      rst_n = 1'b1;

      // R1: plain scaled add
      apply("R1", 64'd1, 64'd2, 1'b0, 2'd3, 1'b1, 4'd2, 1'b0);
      apply("R1", 64'h0123_4567_89AB_CDEF, 64'h1111, 1'b1, 2'd2, 1'b1, 4'd14, 1'b0);
      // R2: doubleword sign overflow, N xor V is false
      apply("R2", 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 1'b0, 2'd0, 1'b1, 4'd4, 1'b1);
      apply("R2", 64'h0000_0000_7FFF_FFFF, 64'd0, 1'b1, 2'd0, 1'b0, 4'd12, 1'b1);
      // R3: word mode, bit 30 differs from bit 31
      apply("R3", 64'h0000_0000_4000_0000, 64'd0, 1'b0, 2'd1, 1'b0, 4'd12, 1'b1);
      apply("R3", 64'hC000_0000_0000_0000, 64'd0, 1'b0, 2'd1, 1'b1, 4'd13, 1'b1);
      // R4: bit 60 lies inside a shift of 3 but outside a shift of 2
      apply("R4", 64'h1000_0000_0000_0000, 64'd0, 1'b0, 2'd3, 1'b1, 4'd12, 1'b1);
      apply("R4", 64'h1000_0000_0000_0000, 64'd0, 1'b0, 2'd2, 1'b1, 4'd12, 1'b1);
      apply("R4", 64'h0000_0000_E000_0000, 64'd0, 1'b0, 2'd2, 1'b0, 4'd6, 1'b1);
      // R5: carries out of bit 63 and into bit 32
      apply("R5", 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 1'b0, 2'd0, 1'b1, 4'd8, 1'b0);
      apply("R5", 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 1'b0, 2'd0, 1'b1, 4'd11, 1'b0);
      apply("R5", 64'h0000_0000_FFFF_FFFF, 64'd0, 1'b1, 2'd0, 1'b0, 4'd9, 1'b0);
      // R6: set bit just under the word sign lost to the shift
      apply("R6", 64'h0000_0000_2000_0000, 64'd0, 1'b0, 2'd2, 1'b0, 4'd8, 1'b0);
      apply("R6", 64'h0000_0000_2000_0000, 64'd0, 1'b0, 2'd1, 1'b0, 4'd8, 1'b0);
      // R8: low word zero while the doubleword is not
      apply("R8", 64'h0000_0000_FFFF_FFFF, 64'd1, 1'b0, 2'd0, 1'b0, 4'd2, 1'b0);
      apply("R8", 64'h0000_0000_FFFF_FFFF, 64'd1, 1'b0, 2'd0, 1'b1, 4'd2, 1'b0);
      apply("R8", 64'h0000_0000_8000_0000, 64'd0, 1'b0, 2'd0, 1'b0, 4'd4, 1'b0);
      // R7: every selector and both senses
      for (int c = 0; c < 16; c++) begin
         apply("R7", 64'h8000_0000_0000_0003, 64'h8000_0000_0000_0000, 1'b0, 2'd0,
               1'b1, 4'(c), 1'b1);
         apply("R7", 64'h0000_0000_0000_0010, 64'hFFFF_FFFF_FFFF_FFC0, 1'b0, 2'd2,
               1'b0, 4'(c), 1'b0);
      end
      // R7, R9: mixed random operands
      for (int i = 0; i < 400; i++) begin
         logic [63:0] ra, rb;
         ra = {$urandom, $urandom};
         rb = {$urandom, $urandom};
         if (i % 3 == 0) ra[63:28] = ra[63] ? '1 : '0;
         apply("R7", ra, rb, 1'($urandom), 2'($urandom), 1'($urandom),
               4'($urandom), 1'($urandom));
      end
      // R10: a return to reset clears the outputs
      @(negedge clk);
      rst_n = 1'b0;
      @(posedge clk);
      @(negedge clk);
      chk("R10", "sum", sum_o, 64'd0);
      chk("R10", "flags", {59'd0, sv_o, uv_o, cond_o, trap_o, 1'b0}, 64'd0);
      done = 1'b1;
      summary();
      $finish;
   end
endmodule